// File: doc/BRIEF.md
# Keyboard Controller Register Interface

This block presents a keyboard controller to a host processor as a pair of byte-wide registers on a simple memory-mapped bus. One address holds the data register. The second address reads as a status byte and accepts command bytes when written. Host software checks the status byte to learn whether a scancode is waiting and whether the controller is still handling the previous write. It then reads the data register, issues commands, or supplies follow-on bytes.

On the device side, scancode bytes arrive on a valid/ready byte stream. The stream never applies back-pressure: `scan_ready` is high whenever the block is out of reset. A byte offered while the keyboard is disabled is discarded. A byte offered while a previous byte still waits for the host is also discarded, and this raises a sticky overrun flag. Three commands are recognised: enable the keyboard, run a self test, and set the LEDs. After a set-LED command, the next data-register write becomes the LED state and drives the three-bit LED output.

Top module: `kbd_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the LED output is 0 and the keyboard is disabled.
- R2: The data register is at address 0 and the status/command register is at address 1. Status bit 0 is the output-buffer-full flag, bit 1 the input-buffer-full flag, bit 2 the self-test-passed flag, bit 3 is 1 when the last accepted write was a command, bit 7 the overrun flag, and bits 6:4 always read 0.
- R3: While the keyboard is disabled, offered scancodes are discarded. After command 0xAE is processed, a scancode offered while the output buffer is empty is stored and sets status bit 0.
- R4: A data-register read returns the stored byte, and the read clears status bit 0.
- R5: A scancode offered while status bit 0 is set is dropped, the stored byte is kept, and status bit 7 is set. Bit 7 stays set until a status read, which returns it as 1 and clears it.
- R6: Status bit 1 reads 1 for exactly the one cycle after a write is accepted. A write made in that cycle is ignored.
- R7: Command 0xAA starts a self test. No sooner than ST_CYCLES cycles and no later than ST_CYCLES+4 cycles after the write, the data register holds 0x55 and status bits 0 and 2 are set.
- R8: After command 0xED, the next accepted data-register write sets the LED output to bits 2:0 of that byte (bit 2 caps lock, bit 1 num lock, bit 0 scroll lock). The LED output changes at no other time, and a data write with no set-LED command pending leaves it unchanged.
- R9: A command byte other than 0xAA, 0xAE or 0xED leaves the LEDs, the keyboard-enable state and status bits 0, 2 and 7 unchanged.
- R10: `scan_ready` is low while reset is asserted and high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and strobe |
| scan_valid | input | 1 | Scancode byte offered |
| scan_ready | output | 1 | Always high out of reset |
| scan_byte | input | 8 | Scancode byte |
| led_out | output | LED_W | LED state |

## Verification
The scoreboard carries scancodes through with several byte patterns: all zeros, all ones, alternating bits and ordinary codes. These show that the stored byte is the one offered and not a stale or mixed value. Back-to-back offers while the buffer is full separate a correctly dropped byte from one that overwrites the stored byte. A write immediately after a set-LED command shows whether the busy window truly blocks writes. A plain data write after the LEDs are set shows that LED capture is tied to the pending command. Polling the self test each cycle bounds its latency on both sides.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam logic [7:0] CMD_SELFTEST = 8'hAA;
  localparam logic [7:0] CMD_ENABLE   = 8'hAE;
  localparam logic [7:0] CMD_SETLED   = 8'hED;
  localparam logic [7:0] SELFTEST_OK  = 8'h55;

  localparam int ST_OBF  = 0;
  localparam int ST_IBF  = 1;
  localparam int ST_SYS  = 2;
  localparam int ST_CMD  = 3;
  localparam int ST_OVR  = 7;
endpackage

// File: rtl/kbd_hostif.sv
module kbd_hostif #(
  parameter int ADDR_W    = 2,
  parameter int DATA_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        status_byte,
  input  logic [7:0]        data_byte,
  output logic              ibf,
  output logic              pend_is_cmd,
  output logic [7:0]        pend_byte,
  output logic              last_cmd,
  output logic              rd_data_stb,
  output logic              rd_stat_stb
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic hit_data, hit_stat;
  assign hit_data = (bus_addr == A_DATA);
  assign hit_stat = (bus_addr == A_STAT);
  assign rd_data_stb = bus_rd && hit_data;
  assign rd_stat_stb = bus_rd && hit_stat;

  always_comb begin
    bus_rdata = '0;
    if (rd_data_stb)      bus_rdata = data_byte;
    else if (rd_stat_stb) bus_rdata = status_byte;
  end

  // A write is latched only while the input buffer is empty; the
  // buffer is drained by the processing step on the next edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf         <= 1'b0;
      pend_is_cmd <= 1'b0;
      pend_byte   <= '0;
      last_cmd    <= 1'b0;
    end else if (ibf) begin
      ibf <= 1'b0;
    end else if (bus_wr && (hit_data || hit_stat)) begin
      ibf         <= 1'b1;
      pend_byte   <= bus_wdata;
      pend_is_cmd <= hit_stat;
      last_cmd    <= hit_stat;
    end
  end
endmodule

// File: rtl/kbd_cmd.sv
module kbd_cmd
  import kbd_pkg::*;
#(
  parameter int ST_CYCLES = 16,
  parameter int LED_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc_valid,
  input  logic             proc_is_cmd,
  input  logic [7:0]       proc_byte,
  output logic             kbd_en,
  output logic [LED_W-1:0] led,
  output logic             st_done,
  output logic             sys_ok
);
  localparam int CW = $clog2(ST_CYCLES + 1);
  localparam logic [CW-1:0] ST_LOAD = CW'(ST_CYCLES);
  localparam logic [CW-1:0] ST_LAST = CW'(1);

  logic          want_led;
  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbd_en   <= 1'b0;
      led      <= '0;
      want_led <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      st_done  <= 1'b0;
      sys_ok   <= 1'b0;
    end else begin
      st_done <= 1'b0;
      if (busy) begin
        if (cnt == ST_LAST) begin
          busy    <= 1'b0;
          st_done <= 1'b1;
          sys_ok  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (proc_valid) begin
        if (proc_is_cmd) begin
          case (proc_byte)
            CMD_SELFTEST: if (!busy) begin
              busy <= 1'b1;
              cnt  <= ST_LOAD;
            end
            CMD_ENABLE:   kbd_en   <= 1'b1;
            CMD_SETLED:   want_led <= 1'b1;
            default:      ;
          endcase
        end else if (want_led) begin
          led      <= proc_byte[LED_W-1:0];
          want_led <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/kbd_outbuf.sv
module kbd_outbuf
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_valid,
  input  logic [7:0] scan_byte,
  input  logic       kbd_en,
  input  logic       st_done,
  input  logic       rd_data_stb,
  input  logic       rd_stat_stb,
  output logic       obf,
  output logic [7:0] data_q,
  output logic       overrun
);
  logic offer;
  assign offer = scan_valid && kbd_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf     <= 1'b0;
      data_q  <= '0;
      overrun <= 1'b0;
    end else begin
      if (rd_stat_stb) overrun <= 1'b0;
      if (rd_data_stb) obf <= 1'b0;
      if (st_done) begin
        data_q <= SELFTEST_OK;
        obf    <= 1'b1;
        if (offer) overrun <= 1'b1;
      end else if (offer) begin
        if (obf) begin
          overrun <= 1'b1;
        end else begin
          data_q <= scan_byte;
          obf    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kbd_ctrl.sv
module kbd_ctrl
  import kbd_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int ST_CYCLES = 16,
  parameter int LED_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              scan_valid,
  output logic              scan_ready,
  input  logic [7:0]        scan_byte,
  output logic [LED_W-1:0]  led_out
);
  logic       ibf, pend_is_cmd, last_cmd, rd_data_stb, rd_stat_stb;
  logic [7:0] pend_byte, data_q, status_byte;
  logic       kbd_en, st_done, sys_ok, obf, overrun;

  always_comb begin
    status_byte         = '0;
    status_byte[ST_OBF] = obf;
    status_byte[ST_IBF] = ibf;
    status_byte[ST_SYS] = sys_ok;
    status_byte[ST_CMD] = last_cmd;
    status_byte[ST_OVR] = overrun;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) scan_ready <= 1'b0;
    else        scan_ready <= 1'b1;
  end

  kbd_hostif #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .STAT_ADDR(STAT_ADDR)) u_host (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_byte(status_byte),
    .data_byte(data_q), .ibf(ibf), .pend_is_cmd(pend_is_cmd), .pend_byte(pend_byte),
    .last_cmd(last_cmd), .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb)
  );

  kbd_cmd #(.ST_CYCLES(ST_CYCLES), .LED_W(LED_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .proc_valid(ibf), .proc_is_cmd(pend_is_cmd),
    .proc_byte(pend_byte), .kbd_en(kbd_en), .led(led_out), .st_done(st_done),
    .sys_ok(sys_ok)
  );

  kbd_outbuf u_obuf (
    .clk(clk), .rst_n(rst_n), .scan_valid(scan_valid), .scan_byte(scan_byte),
    .kbd_en(kbd_en), .st_done(st_done), .rd_data_stb(rd_data_stb),
    .rd_stat_stb(rd_stat_stb), .obf(obf), .data_q(data_q), .overrun(overrun)
  );
endmodule

// File: rtl/kbd_ctrl_chk.sv
module kbd_ctrl_chk #(
  parameter int LED_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ibf,
  input logic             obf,
  input logic             overrun,
  input logic             st_done,
  input logic             rd_data_stb,
  input logic             rd_stat_stb,
  input logic             scan_ready,
  input logic [LED_W-1:0] led_out
);
  // R6
  ibf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ibf |=> !ibf);

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_stb && obf && !st_done) |=> !obf);

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rd_stat_stb) |=> overrun);

  // R8
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ibf |=> $stable(led_out));

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_ready |=> scan_ready);

  // R7
  st_sets_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> obf);
endmodule

bind kbd_ctrl kbd_ctrl_chk #(.LED_W(LED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ibf(ibf), .obf(obf), .overrun(overrun),
  .st_done(st_done), .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
  .scan_ready(scan_ready), .led_out(led_out)
);

// File: tb/sim_kbd_ctrl.sv
module sim_kbd_ctrl;
  localparam int ST = 16;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       scan_valid = 1'b0, scan_ready;
  logic [7:0] scan_byte = '0;
  logic [2:0] led_out;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  kbd_ctrl #(.ST_CYCLES(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scan_valid(scan_valid),
    .scan_ready(scan_ready), .scan_byte(scan_byte), .led_out(led_out)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: offers a scancode; pushes it to the scoreboard when it must be kept.
  task automatic send_scan(logic [7:0] b, bit keep);
    scan_byte = b; scan_valid = 1'b1;
    @(negedge clk);
    scan_valid = 1'b0;
    if (keep) exp_q.push_back(b);
  endtask

  // Monitor: reads the data register and compares with the scoreboard head.
  task automatic take_data(string req);
    logic [7:0] d;
    logic [7:0] e;
    bus_read(A_DATA, d);
    if (exp_q.size() == 0) begin
      check({req, " unexpected byte"}, d, 0);
    end else begin
      e = exp_q.pop_front();
      check(req, d, e);
    end
  endtask

  task automatic stat(string req, logic [7:0] exp);
    logic [7:0] s;
    bus_read(A_STAT, s);
    check(req, s, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int polls;
    repeat (3) @(negedge clk);
    check("R10 ready low in reset", scan_ready, 0);
    rst_n = 1'b1;
    idle(1);
    check("R10 ready after reset", scan_ready, 1);
    stat("R1 status after reset", 8'h00);
    check("R1 leds after reset", led_out, 0);

    // R3: disabled keyboard drops scancodes
    send_scan(8'h1C, 0);
    stat("R3 disabled drop", 8'h00);

    // R9: unknown command has no effect
    bus_write(A_STAT, 8'h12);
    idle(2);
    send_scan(8'h22, 0);
    stat("R9 unknown cmd status (R2 bit3)", 8'h08);
    check("R9 unknown cmd leds", led_out, 0);

    // R3/R4: enable, then deliver
    bus_write(A_STAT, 8'hAE);
    idle(2);
    send_scan(8'h1C, 1);
    stat("R3 enabled obf set", 8'h09);
    take_data("R4 data read");
    stat("R4 obf cleared", 8'h08);

    // R5: overrun
    send_scan(8'h32, 1);
    send_scan(8'h33, 0);
    stat("R5 overrun flagged", 8'h89);
    stat("R5 overrun cleared by status read", 8'h09);
    take_data("R5 kept first byte");

    // R4: byte patterns
    send_scan(8'h00, 1); take_data("R4 pattern 00");
    send_scan(8'hFF, 1); take_data("R4 pattern FF");
    send_scan(8'hA5, 1); take_data("R4 pattern A5");

    // R6: busy window after a data write, R8 no LED change
    bus_write(A_DATA, 8'h44);
    stat("R6 ibf set after write", 8'h02);
    stat("R6 ibf cleared", 8'h00);
    check("R8 plain data write leaves leds", led_out, 0);

    // R6/R8: write during busy is ignored, next write sets LEDs
    bus_write(A_STAT, 8'hED);
    bus_write(A_DATA, 8'h07);
    idle(2);
    check("R6 write during busy ignored", led_out, 0);
    bus_write(A_DATA, 8'h05);
    idle(2);
    check("R8 led byte accepted", led_out, 5);
    check("R8 caps lock is bit 2", led_out[2], 1);
    bus_write(A_DATA, 8'h02);
    idle(2);
    check("R8 second data write ignored", led_out, 5);

    // R7: self test
    bus_write(A_STAT, 8'hAA);
    polls = 0;
    s = 8'h00;
    while (!s[0] && polls < ST + 10) begin
      bus_read(A_STAT, s);
      if (!s[0]) polls++;
    end
    check("R7 not early", (polls >= ST) ? 1 : 0, 1);
    check("R7 not late", (polls <= ST + 4) ? 1 : 0, 1);
    stat("R7 status after self test", 8'h0D);
    exp_q.push_back(8'h55);
    take_data("R7 self test result");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule